// File: doc/BRIEF.md
# Strict-Priority Read Scheduler for a Multi-Queue FIFO

This block drives the read side of an external multi-queue FIFO so that traffic of higher service levels always leaves first. Every cycle it reads each queue's empty and almost-empty status. It picks the queue to read next and drives the read queue address, a one-cycle address-latch strobe and the read enable. Queue index 0 is the most delay-sensitive class. Larger indices are served only when every smaller index lacks data.

The FIFO returns a word a fixed number of read cycles (`RD_LAT`, default 3) after the cycle in which it was requested. The scheduler uses the almost-empty flag as a look-ahead and moves to the next queue while the current one still holds words in flight, so the read enable never drops during a queue change. A short tag pipeline of `RD_LAT` stages follows each read slot. Each word on the read bus therefore leaves with the index of the queue it came from and a valid bit. The valid bit is cleared for a slot whose queue was already empty at the read, because that slot returns filler (all ones) and not data.

Top module: `mq_prio_rd_sched`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `rd_en`, `rd_qlatch` and `out_valid` are 0 and `rd_qaddr` is 0.
- R2: A queue has data above threshold when its `q_empty` bit and its `q_almost_empty` bit are both 0. If any queue has data above threshold in cycle c, then in cycle c+1 `rd_en` is 1 and `rd_qaddr` is the lowest such index (index 0 has the highest priority).
- R3: If no queue has data above threshold in cycle c but some `q_empty` bit is 0, then in cycle c+1 `rd_en` is 1 and `rd_qaddr` is the lowest index whose `q_empty` bit is 0.
- R4: If every `q_empty` bit is 1 in cycle c, `rd_en` is 0 in cycle c+1.
- R5: `rd_qlatch` is 1 in exactly those cycles where `rd_en` is 1 and either `rd_en` was 0 in the previous cycle or `rd_qaddr` differs from its previous-cycle value.
- R6: For a cycle c with `rd_en` = 1, the word on `rd_data` in cycle c+`RD_LAT` is shown on `out_data`, and `out_qid` in that cycle equals `rd_qaddr` of cycle c.
- R7: If the queue addressed in a read cycle c has its `q_empty` bit at 1 in that cycle, `out_valid` is 0 in cycle c+`RD_LAT`. Otherwise `out_valid` is 1 there. In cycles that follow no read, `out_valid` is 0.
- R8: `rd_en` stays 1 in every cycle that follows a cycle with any `q_empty` bit at 0, including cycles where the queue address changes.
- R9: When a queue of smaller index than the one being read gains data above threshold in cycle c, `rd_qaddr` switches to it in cycle c+1, with `rd_qlatch` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_empty | input | NUM_Q | Per-queue empty status, 1 = empty |
| q_almost_empty | input | NUM_Q | Per-queue almost-empty status, 1 = at or below threshold |
| rd_data | input | DATA_W | Read bus from the FIFO |
| rd_qaddr | output | $clog2(NUM_Q) | Queue addressed by the current read slot |
| rd_qlatch | output | 1 | Strobe that latches a new read queue address |
| rd_en | output | 1 | Read enable |
| out_data | output | DATA_W | Word leaving the read pipeline |
| out_valid | output | 1 | `out_data` holds real queue data |
| out_qid | output | $clog2(NUM_Q) | Source queue of `out_data` |

## Verification
The status-to-request results (R2, R3, R4, R9) are due one cycle after the flags that cause them. A per-cycle monitor keeps last cycle's flags and last cycle's address and enable, then compares the present outputs against them. Tag results (R6, R7) are due `RD_LAT` cycles after the read slot. The bench counts edges from the first read enable to the first valid word, and it checks every valid word for its queue field and per-queue sequence number. All outputs are sampled at the falling edge, half a cycle after the registers settle. The FIFO model updates its counts and its delayed read bus only on rising edges.

// File: rtl/mq_sched_pkg.sv
package mq_sched_pkg;

   // index width for a set of n queues; at least one bit
   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/mqs_prio_pick.sv
module mqs_prio_pick #(
   parameter int unsigned N  = 4,
   localparam int unsigned QW = mq_sched_pkg::idx_w(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic [QW-1:0] idx
);
   logic [N:0]   seen;
   logic [N-1:0] win;

   assign seen[0] = 1'b0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_chain
         assign seen[i+1] = seen[i] | req[i];
         assign win[i]    = req[i] & ~seen[i];
      end
   endgenerate

   assign any = seen[N];

   always_comb begin
      idx = '0;
      for (int i = 0; i < N; i++) begin
         if (win[i]) idx = idx | QW'(i);
      end
   end
endmodule

// File: rtl/mqs_tag_pipe.sv
module mqs_tag_pipe #(
   parameter int unsigned QW    = 2,
   parameter int unsigned DEPTH = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_v,
   input  logic [QW-1:0] in_q,
   output logic          out_v,
   output logic [QW-1:0] out_q
);
   generate
      if (DEPTH == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               out_v <= 1'b0;
               out_q <= '0;
            end else begin
               out_v <= in_v;
               out_q <= in_q;
            end
         end
      end else begin : g_chain
         logic [DEPTH-1:0] v_sr;
         logic [QW-1:0]    q_sr [DEPTH];

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               v_sr <= '0;
               for (int i = 0; i < DEPTH; i++) q_sr[i] <= '0;
            end else begin
               v_sr    <= {v_sr[DEPTH-2:0], in_v};
               q_sr[0] <= in_q;
               for (int i = 1; i < DEPTH; i++) q_sr[i] <= q_sr[i-1];
            end
         end

         assign out_v = v_sr[DEPTH-1];
         assign out_q = q_sr[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/mq_prio_rd_sched.sv
module mq_prio_rd_sched #(
   parameter int unsigned NUM_Q  = 4,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned RD_LAT = 3,
   localparam int unsigned QW    = mq_sched_pkg::idx_w(NUM_Q)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_Q-1:0]  q_empty,
   input  logic [NUM_Q-1:0]  q_almost_empty,
   input  logic [DATA_W-1:0] rd_data,
   output logic [QW-1:0]     rd_qaddr,
   output logic              rd_qlatch,
   output logic              rd_en,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic [QW-1:0]     out_qid
);
   generate
      if (NUM_Q < 2)   begin : g_bad_nq  $error("NUM_Q must be at least 2");  end
      if (RD_LAT < 1)  begin : g_bad_lat $error("RD_LAT must be at least 1"); end
      if (DATA_W < 1)  begin : g_bad_dw  $error("DATA_W must be at least 1"); end
   endgenerate

   // candidate sets: above threshold first, then anything non-empty
   logic [NUM_Q-1:0] above_thr, has_data;
   assign above_thr = ~q_empty & ~q_almost_empty;
   assign has_data  = ~q_empty;

   logic          any_above, any_data;
   logic [QW-1:0] pick_above, pick_data, nxt_q;

   mqs_prio_pick #(.N(NUM_Q)) u_pick_above (
      .req (above_thr),
      .any (any_above),
      .idx (pick_above)
   );

   mqs_prio_pick #(.N(NUM_Q)) u_pick_data (
      .req (has_data),
      .any (any_data),
      .idx (pick_data)
   );

   assign nxt_q = any_above ? pick_above : pick_data;

   // issue registers
   logic          en_r, latch_r;
   logic [QW-1:0] addr_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_r    <= 1'b0;
         latch_r <= 1'b0;
         addr_r  <= '0;
      end else begin
         en_r    <= any_data;
         latch_r <= any_data & (~en_r | (nxt_q != addr_r));
         if (any_data) addr_r <= nxt_q;
      end
   end

   assign rd_en     = en_r;
   assign rd_qlatch = latch_r;
   assign rd_qaddr  = addr_r;

   // a slot carries data only if its queue was non-empty when it was read
   logic slot_ok;
   assign slot_ok = en_r & ~q_empty[addr_r];

   mqs_tag_pipe #(.QW(QW), .DEPTH(RD_LAT)) u_tags (
      .clk   (clk),
      .rst_n (rst_n),
      .in_v  (slot_ok),
      .in_q  (addr_r),
      .out_v (out_valid),
      .out_q (out_qid)
   );

   assign out_data = rd_data;
endmodule

// File: rtl/mq_prio_rd_sched_chk.sv
module mq_prio_rd_sched_chk #(
   parameter int unsigned NUM_Q = 4,
   parameter int unsigned QW    = 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NUM_Q-1:0] q_empty,
   input logic [NUM_Q-1:0] q_almost_empty,
   input logic [QW-1:0]    rd_qaddr,
   input logic             rd_qlatch,
   input logic             rd_en
);
   AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (&q_empty) |=> !rd_en); // R4

   AST_NO_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&q_empty)) |=> rd_en); // R8

   AST_TOP_CLASS_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_empty[0] && !q_almost_empty[0]) |=> (rd_en && rd_qaddr == '0)); // R2

   AST_STROBE_ON_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && $past(rd_en) && rd_qaddr != $past(rd_qaddr)) |-> rd_qlatch); // R5

   AST_STROBE_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_qlatch |-> rd_en); // R5
endmodule

bind mq_prio_rd_sched mq_prio_rd_sched_chk #(.NUM_Q(NUM_Q), .QW(QW)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .q_empty        (q_empty),
   .q_almost_empty (q_almost_empty),
   .rd_qaddr       (rd_qaddr),
   .rd_qlatch      (rd_qlatch),
   .rd_en          (rd_en)
);

// File: tb/mq_prio_rd_sched_test.sv
module mq_prio_rd_sched_test;
   localparam int NQ    = 4;
   localparam int DW    = 16;
   localparam int LAT   = 3;
   localparam int QW    = 2;
   localparam int AE_TH = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [NQ-1:0] q_empty, q_ae;
   logic [DW-1:0] rd_data;
   logic [QW-1:0] rd_qaddr, out_qid;
   logic          rd_qlatch, rd_en, out_valid;
   logic [DW-1:0] out_data;

   mq_prio_rd_sched #(.NUM_Q(NQ), .DATA_W(DW), .RD_LAT(LAT)) uut (
      .clk            (clk),
      .rst_n          (rst_n),
      .q_empty        (q_empty),
      .q_almost_empty (q_ae),
      .rd_data        (rd_data),
      .rd_qaddr       (rd_qaddr),
      .rd_qlatch      (rd_qlatch),
      .rd_en          (rd_en),
      .out_data       (out_data),
      .out_valid      (out_valid),
      .out_qid        (out_qid)
   );

   int vectors = 0;
   int errors  = 0;
   int cnt[NQ];
   int add_n[NQ];
   int pop_seq[NQ];
   int exp_seq[NQ];
   int got[NQ];
   int issued = 0;
   int strobes = 0;
   bit mon_on = 1'b0;
   logic [DW-1:0] d1, d2;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      vectors++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   always_comb begin
      for (int q = 0; q < NQ; q++) begin
         q_empty[q] = (cnt[q] == 0);
         q_ae[q]    = (cnt[q] <= AE_TH);
      end
   end

   // FIFO model: pops at the read edge, word appears LAT cycles after the read cycle
   initial begin
      logic [DW-1:0] w;
      for (int q = 0; q < NQ; q++) begin
         cnt[q] = 0; add_n[q] = 0; pop_seq[q] = 0; exp_seq[q] = 0; got[q] = 0;
      end
      d1 = '1; d2 = '1; rd_data = '1;
      forever begin
         @(posedge clk);
         w = '1;
         for (int q = 0; q < NQ; q++) begin
            int n;
            n = cnt[q] + add_n[q];
            if (rd_en && rd_qaddr == QW'(q) && cnt[q] > 0) begin
               w = {4'(q), 12'(pop_seq[q])};
               pop_seq[q] <= pop_seq[q] + 1;
               n = n - 1;
            end
            cnt[q]   <= n;
            add_n[q] <= 0;
         end
         d1      <= w;
         d2      <= d1;
         rd_data <= d2;
      end
   end

   // per-cycle monitor against last cycle's flags and outputs
   initial begin
      logic [NQ-1:0] pe, pae;
      logic          p_en;
      logic [QW-1:0] p_addr;
      pe = '1; pae = '1; p_en = 1'b0; p_addr = '0;
      forever begin
         @(negedge clk);
         if (mon_on) begin
            bit exp_en, found;
            int exp_a;
            exp_en = ~(&pe);
            found  = 1'b0;
            exp_a  = 0;
            for (int q = NQ - 1; q >= 0; q--) if (!pe[q] && !pae[q]) begin exp_a = q; found = 1'b1; end
            if (!found) for (int q = NQ - 1; q >= 0; q--) if (!pe[q]) exp_a = q;
            // R4 / R8: enable follows any data one cycle later
            chk(rd_en == exp_en, exp_en ? "R8 read enable" : "R4 idle enable", int'(rd_en), int'(exp_en));
            // R2 / R3: address selection
            if (exp_en) chk(int'(rd_qaddr) == exp_a, found ? "R2 priority pick" : "R3 fallback pick",
                            int'(rd_qaddr), exp_a);
            // R5: strobe on new address or restart
            chk(rd_qlatch == (rd_en && (!p_en || rd_qaddr != p_addr)), "R5 latch strobe",
                int'(rd_qlatch), int'(rd_en && (!p_en || rd_qaddr != p_addr)));
            if (rd_en) issued++;
            if (rd_qlatch) strobes++;
            // R6 / R7: every valid word carries its own queue and next sequence number
            if (out_valid) begin
               chk(int'(out_data[15:12]) == int'(out_qid), "R6 tag matches source", int'(out_data[15:12]), int'(out_qid));
               chk(int'(out_data[11:0]) == (exp_seq[out_qid] & 12'hFFF), "R7 in-order valid data",
                   int'(out_data[11:0]), exp_seq[out_qid]);
               exp_seq[out_qid]++;
               got[out_qid]++;
            end
         end
         pe = q_empty; pae = q_ae; p_en = rd_en; p_addr = rd_qaddr;
      end
   end

   task automatic load(input int q, input int n);
      add_n[q] = n;
   endtask

   task automatic wait_drain();
      int guard;
      guard = 0;
      while ((cnt[0] + cnt[1] + cnt[2] + cnt[3]) != 0 && guard < 2000) begin
         @(negedge clk);
         guard++;
      end
      repeat (LAT + 4) @(negedge clk);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(rd_en == 1'b0, "R1 reset rd_en", int'(rd_en), 0);
      chk(rd_qlatch == 1'b0, "R1 reset rd_qlatch", int'(rd_qlatch), 0);
      chk(out_valid == 1'b0, "R1 reset out_valid", int'(out_valid), 0);
      chk(rd_qaddr == '0, "R1 reset rd_qaddr", int'(rd_qaddr), 0);
      rst_n = 1'b1;
      mon_on = 1'b1;
      @(negedge clk);
      chk(rd_en == 1'b0 && out_valid == 1'b0, "R1 after release", int'(rd_en), 0);
   endtask

   task automatic t_single_drain();
      int t_en, t_val, k, g0, i0, s0;
      g0 = got[2]; i0 = issued; s0 = strobes;
      t_en = -1; t_val = -1; k = 0;
      load(2, 6);
      while (t_val < 0 && k < 50) begin
         @(negedge clk);
         if (rd_en && t_en < 0) t_en = k;
         if (out_valid && t_val < 0) t_val = k;
         k++;
      end
      chk(t_val - t_en == LAT, "R6 word due LAT cycles after read", t_val - t_en, LAT);
      wait_drain();
      chk(got[2] - g0 == 6, "R7 valid words from queue 2", got[2] - g0, 6);
      // one read is issued past the last word and must come back invalid
      chk(issued - i0 == 7, "R7 over-read flagged invalid", issued - i0, 7);
      chk(strobes - s0 == 1, "R5 one strobe for one queue", strobes - s0, 1);
      chk(rd_en == 1'b0, "R4 idle after drain", int'(rd_en), 0);
   endtask

   task automatic t_mixed_priority();
      int first_q;
      first_q = -1;
      load(1, 8); load(3, 8); load(0, 8);
      for (int q = 0; q < NQ; q++) got[q] = 0;
      repeat (2) @(negedge clk);
      chk(rd_en && rd_qaddr == 2'd0, "R2 highest class read first", int'(rd_qaddr), 0);
      for (int k = 0; k < 10 && first_q < 0; k++) begin
         @(negedge clk);
         if (out_valid) first_q = int'(out_qid);
      end
      chk(first_q == 0, "R2 first word from queue 0", first_q, 0);
      wait_drain();
      chk(got[0] == 8, "R3 queue 0 fully drained", got[0], 8);
      chk(got[1] == 8, "R3 queue 1 fully drained", got[1], 8);
      chk(got[3] == 8, "R3 queue 3 fully drained", got[3], 8);
   endtask

   task automatic t_preempt();
      load(3, 12);
      repeat (5) @(negedge clk);
      chk(rd_qaddr == 2'd3, "R9 reading queue 3 before preemption", int'(rd_qaddr), 3);
      load(0, 6);
      @(negedge clk);
      @(negedge clk);
      chk(rd_qaddr == 2'd0, "R9 switch to queue 0 next cycle", int'(rd_qaddr), 0);
      chk(rd_qlatch == 1'b1, "R9 strobe on preemption", int'(rd_qlatch), 1);
      wait_drain();
      chk(cnt[3] == 0 && cnt[0] == 0, "R8 all data drained", cnt[3] + cnt[0], 0);
   endtask

   task automatic t_idle();
      for (int k = 0; k < 5; k++) begin
         @(negedge clk);
         chk(rd_en == 1'b0, "R4 no read while empty", int'(rd_en), 0);
         chk(out_valid == 1'b0, "R7 no valid while idle", int'(out_valid), 0);
      end
   endtask

   initial begin
      t_reset();
      t_single_drain();
      t_mixed_priority();
      t_preempt();
      t_idle();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end
endmodule